// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a small data cache placed between a byte-wide processor load/store port and a main-memory port that moves one whole 64-bit line per transfer. It holds 64 bytes as eight lines of eight bytes. Each line has a stored tag, a valid flag and a modified flag. Every processor address is cut into three fields: a byte offset, a line index and a tag. A lookup hits only when the indexed line is valid and its stored tag equals the address tag.

Stores that hit change only the cached byte and mark the line modified. Any miss, whether from a load or a store, allocates the line. If the line being replaced is valid and modified, it is first written out to the address rebuilt from its stored tag and its index. The line is then refilled from the line-aligned address of the request. A store miss merges its byte into the refilled line. A clean command walks every line in ascending index order. It writes out each valid modified line and leaves the line valid and unmodified.

The processor side uses a valid/ready handshake and holds one request at a time. Ready drops for the whole of a miss or a clean. Each accepted request produces one response pulse, which carries the read byte for loads.

Top module: `dm_writeback_cache`

## Requirements
- R1: After reset, cpu_ready_o is 1 and cpu_rvalid_o and mem_req_o are 0. Every line is invalid, so the first access to each line index misses.
- R2: The address fields are fixed. The byte offset is bits [2:0], the line index is bits [5:3], and the tag is every bit above bit 5. Addresses with the same tag and index hit in the same line at any offset. A different tag at the same index misses.
- R3: A load or store that hits raises cpu_rvalid_o in the cycle right after acceptance and issues no memory transfer. For a load, cpu_rdata_o then holds the addressed byte.
- R4: A miss issues a memory read (mem_we_o=0) of the whole line at the request address with bits [2:0] cleared. cpu_ready_o stays 0 until the response.
- R5: When the refill is acknowledged, the line becomes valid with the new tag. The response returns byte offset k of the line, taken from bits [8k+7:8k] of the line data.
- R6: If the victim line is valid and modified, a memory write (mem_we_o=1) of its current contents to {stored tag, index, 3'b000} comes before the refill read.
- R7: A store hit updates only the cached byte and marks the line modified. Memory is not written.
- R8: A store miss allocates the line (with write-out if needed). It then merges the store byte into the refilled line and marks the line modified, so a later replacement of that line writes it out.
- R9: A clean command (cpu_op_i[1]=1) writes out every valid modified line in ascending index order and clears its modified flag. The line stays valid.
- R10: A clean command issues no transfer for lines that are invalid or unmodified. A second clean right after the first issues none at all.
- R11: While mem_req_o is 1 and mem_ack_i is 0, mem_req_o, mem_we_o and mem_addr_o hold steady. Each acknowledge completes exactly one transfer.

Operation codes on cpu_op_i: 2'b00 load, 2'b01 store, 2'b10 or 2'b11 clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_valid_i | input | 1 | Processor request valid |
| cpu_ready_o | output | 1 | Cache can accept a request |
| cpu_op_i | input | 2 | Operation: 00 load, 01 store, 1x clean |
| cpu_addr_i | input | ADDR_W | Byte address |
| cpu_wdata_i | input | 8 | Store byte |
| cpu_rvalid_o | output | 1 | One-cycle response pulse per request |
| cpu_rdata_o | output | 8 | Load result |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | 1 = line write, 0 = line read |
| mem_addr_o | output | ADDR_W | Line-aligned memory address |
| mem_wdata_o | output | 64 | Line written out |
| mem_ack_i | input | 1 | Transfer done; read data valid this cycle |
| mem_rdata_i | input | 64 | Line read from memory |

## Verification
A hit is due one cycle after the accepting edge. The bench therefore reads the response at the first falling edge after acceptance and requires that no memory transfer was logged. A miss or clean response comes only after the memory model has acknowledged every transfer, and the model's latency is varied from one to three cycles. For misses and cleans, the bench waits for the response pulse, then compares the logged sequence of transfer kinds and addresses with the one it computed. Every written-out line is compared against a flat reference memory at the moment of acknowledge, and every load result is compared against that same reference.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_FLUSH
  } cache_state_e;

  localparam logic [1:0] OP_LOAD  = 2'b00;
  localparam logic [1:0] OP_STORE = 2'b01;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3,
  parameter int TAG_W     = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             fill_we_i,
  input  logic             fill_dirty_i,
  input  logic             set_dirty_i,
  input  logic             clr_dirty_i,
  output logic             hit_o,
  output logic             vic_valid_o,
  output logic             vic_dirty_o,
  output logic [TAG_W-1:0] vic_tag_o
);
  logic [NUM_LINES-1:0] valid_q, dirty_q;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_we_i) begin
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= fill_dirty_i;
    end else if (set_dirty_i) begin
      dirty_q[idx_i] <= 1'b1;
    end else if (clr_dirty_i) begin
      dirty_q[idx_i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_we_i) tag_q[idx_i] <= tag_i;
  end

  // valid gates the compare: an invalid line never hits
  assign vic_valid_o = valid_q[idx_i];
  assign vic_dirty_o = dirty_q[idx_i];
  assign vic_tag_o   = tag_q[idx_i];
  assign hit_o       = valid_q[idx_i] && (tag_q[idx_i] == tag_i);

  assert_clean_only_dirty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_dirty_i |-> (valid_q[idx_i] && dirty_q[idx_i]));

  assert_clean_keeps_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_dirty_i |=> (valid_q[$past(idx_i)] && !dirty_q[$past(idx_i)]));
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3,
  parameter int OFF_W     = 3,
  parameter int LINE_W    = 64
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              line_we_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              byte_we_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [7:0]        byte_i,
  output logic [LINE_W-1:0] line_o
);
  logic [LINE_W-1:0] line_q [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk_i) begin
      if (idx_i == IDX_W'(g)) begin
        if (line_we_i)      line_q[g] <= line_i;
        else if (byte_we_i) line_q[g][{off_i, 3'b000} +: 8] <= byte_i;
      end
    end
  end

  assign line_o = line_q[idx_i];
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int OFF_W     = 3,
  parameter int IDX_W     = 3,
  parameter int TAG_W     = 10,
  parameter int LINE_W    = 64,
  parameter int NUM_LINES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_valid_i,
  input  logic [1:0]        cpu_op_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [7:0]        cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic              cpu_rvalid_o,
  output logic [7:0]        cpu_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [LINE_W-1:0] mem_rdata_i,
  input  logic              hit_i,
  input  logic              vic_valid_i,
  input  logic              vic_dirty_i,
  input  logic [TAG_W-1:0]  vic_tag_i,
  input  logic [LINE_W-1:0] line_i,
  output logic [IDX_W-1:0]  arr_idx_o,
  output logic [TAG_W-1:0]  arr_tag_o,
  output logic              fill_we_o,
  output logic              fill_dirty_o,
  output logic              set_dirty_o,
  output logic              clr_dirty_o,
  output logic              line_we_o,
  output logic [LINE_W-1:0] fill_line_o,
  output logic              byte_we_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [7:0]        byte_o
);
  cache_state_e      state_q;
  logic              req_store_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [7:0]        req_wdata_q;
  logic [IDX_W-1:0]  scan_q;
  logic              rvalid_q;
  logic [7:0]        rdata_q;

  logic [OFF_W-1:0] c_off, r_off;
  logic [IDX_W-1:0] c_idx, r_idx;
  logic [TAG_W-1:0] c_tag, r_tag;
  logic accept, is_clean, is_store, vic_wb, flush_step;

  assign c_off = cpu_addr_i[OFF_W-1:0];
  assign c_idx = cpu_addr_i[OFF_W +: IDX_W];
  assign c_tag = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign r_off = req_addr_q[OFF_W-1:0];
  assign r_idx = req_addr_q[OFF_W +: IDX_W];
  assign r_tag = req_addr_q[ADDR_W-1 -: TAG_W];

  assign cpu_ready_o = (state_q == ST_IDLE);
  assign accept      = cpu_valid_i && cpu_ready_o;
  assign is_clean    = cpu_op_i[1];
  assign is_store    = (cpu_op_i == OP_STORE);

  assign arr_idx_o = (state_q == ST_IDLE)  ? c_idx :
                     (state_q == ST_FLUSH) ? scan_q : r_idx;
  assign arr_tag_o = (state_q == ST_IDLE) ? c_tag : r_tag;

  assign vic_wb     = vic_valid_i && vic_dirty_i;
  assign flush_step = (state_q == ST_FLUSH) && (!vic_wb || mem_ack_i);

  assign mem_req_o  = (state_q == ST_EVICT) || (state_q == ST_FILL) ||
                      ((state_q == ST_FLUSH) && vic_wb);
  assign mem_we_o   = (state_q == ST_EVICT) || (state_q == ST_FLUSH);
  assign mem_addr_o = (state_q == ST_FILL) ? {r_tag, r_idx, {OFF_W{1'b0}}}
                                           : {vic_tag_i, arr_idx_o, {OFF_W{1'b0}}};

  always_comb begin
    fill_line_o = mem_rdata_i;
    if (req_store_q) fill_line_o[{r_off, 3'b000} +: 8] = req_wdata_q;
  end

  assign line_we_o    = (state_q == ST_FILL) && mem_ack_i;
  assign fill_we_o    = line_we_o;
  assign fill_dirty_o = req_store_q;
  assign byte_we_o    = accept && !is_clean && is_store && hit_i;
  assign set_dirty_o  = byte_we_o;
  assign clr_dirty_o  = (state_q == ST_FLUSH) && vic_wb && mem_ack_i;
  assign off_o        = c_off;
  assign byte_o       = cpu_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      req_store_q <= 1'b0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
      scan_q      <= '0;
      rvalid_q    <= 1'b0;
      rdata_q     <= '0;
    end else begin
      rvalid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (is_clean) begin
            scan_q  <= '0;
            state_q <= ST_FLUSH;
          end else if (hit_i) begin
            rvalid_q <= 1'b1;
            rdata_q  <= is_store ? cpu_wdata_i : line_i[{c_off, 3'b000} +: 8];
          end else begin
            req_store_q <= is_store;
            req_addr_q  <= cpu_addr_i;
            req_wdata_q <= cpu_wdata_i;
            state_q     <= vic_wb ? ST_EVICT : ST_FILL;
          end
        end
        ST_EVICT: if (mem_ack_i) state_q <= ST_FILL;
        ST_FILL: if (mem_ack_i) begin
          rvalid_q <= 1'b1;
          rdata_q  <= fill_line_o[{r_off, 3'b000} +: 8];
          state_q  <= ST_IDLE;
        end
        ST_FLUSH: if (flush_step) begin
          if (scan_q == IDX_W'(NUM_LINES - 1)) begin
            rvalid_q <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            scan_q <= scan_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_rvalid_o = rvalid_q;
  assign cpu_rdata_o  = rdata_q;

  assert_hit_next_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !is_clean && hit_i) |=> (cpu_rvalid_o && !mem_req_o));

  assert_busy_not_ready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !cpu_ready_o);

  assert_line_aligned_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[OFF_W-1:0] == '0));

  assert_evict_then_fill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_EVICT) && mem_ack_i) |=> (mem_req_o && !mem_we_o));

  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
endmodule

// File: rtl/dm_writeback_cache.sv
module dm_writeback_cache #(
  parameter int ADDR_W     = 16,
  parameter int NUM_LINES  = 8,
  parameter int LINE_BYTES = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cpu_valid_i,
  output logic                    cpu_ready_o,
  input  logic [1:0]              cpu_op_i,
  input  logic [ADDR_W-1:0]       cpu_addr_i,
  input  logic [7:0]              cpu_wdata_i,
  output logic                    cpu_rvalid_o,
  output logic [7:0]              cpu_rdata_o,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [LINE_BYTES*8-1:0] mem_wdata_o,
  input  logic                    mem_ack_i,
  input  logic [LINE_BYTES*8-1:0] mem_rdata_i
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W = LINE_BYTES * 8;

  logic             hit, vic_valid, vic_dirty;
  logic [TAG_W-1:0] vic_tag, arr_tag;
  logic [IDX_W-1:0] arr_idx;
  logic             fill_we, fill_dirty, set_dirty, clr_dirty;
  logic             line_we, byte_we;
  logic [LINE_W-1:0] fill_line, cur_line;
  logic [OFF_W-1:0] off;
  logic [7:0]       wbyte;

  cache_ctrl #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W),
    .LINE_W(LINE_W), .NUM_LINES(NUM_LINES)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .cpu_valid_i, .cpu_op_i, .cpu_addr_i, .cpu_wdata_i,
    .cpu_ready_o, .cpu_rvalid_o, .cpu_rdata_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_ack_i, .mem_rdata_i,
    .hit_i(hit), .vic_valid_i(vic_valid), .vic_dirty_i(vic_dirty),
    .vic_tag_i(vic_tag), .line_i(cur_line),
    .arr_idx_o(arr_idx), .arr_tag_o(arr_tag),
    .fill_we_o(fill_we), .fill_dirty_o(fill_dirty),
    .set_dirty_o(set_dirty), .clr_dirty_o(clr_dirty),
    .line_we_o(line_we), .fill_line_o(fill_line),
    .byte_we_o(byte_we), .off_o(off), .byte_o(wbyte)
  );

  cache_tag_store #(
    .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_tags (
    .clk_i, .rst_ni,
    .idx_i(arr_idx), .tag_i(arr_tag),
    .fill_we_i(fill_we), .fill_dirty_i(fill_dirty),
    .set_dirty_i(set_dirty), .clr_dirty_i(clr_dirty),
    .hit_o(hit), .vic_valid_o(vic_valid), .vic_dirty_o(vic_dirty),
    .vic_tag_o(vic_tag)
  );

  cache_data_store #(
    .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .OFF_W(OFF_W), .LINE_W(LINE_W)
  ) u_data (
    .clk_i,
    .idx_i(arr_idx),
    .line_we_i(line_we), .line_i(fill_line),
    .byte_we_i(byte_we), .off_i(off), .byte_i(wbyte),
    .line_o(cur_line)
  );

  assign mem_wdata_o = cur_line;
endmodule

// File: tb/sim_dm_writeback_cache.sv
module sim_dm_writeback_cache;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;

  logic clk = 0, rst_n = 0;
  logic cpu_valid = 0, cpu_ready, cpu_rvalid;
  logic [1:0] cpu_op = 0;
  logic [AW-1:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0, cpu_rdata;
  logic mem_req, mem_we, mem_ack = 0;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata = 0;

  logic [7:0] mem_b [0:(1<<AW)-1];
  logic [7:0] ref_b [0:(1<<AW)-1];
  logic ev_we [0:31];
  logic [AW-1:0] ev_addr [0:31];
  int ev_n = 0, mem_lat = 1;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_writeback_cache #(.ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_valid_i(cpu_valid), .cpu_ready_o(cpu_ready), .cpu_op_i(cpu_op),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_rvalid_o(cpu_rvalid), .cpu_rdata_o(cpu_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [7:0] init_byte(int a);
    return 8'((a * 13 + 5) ^ (a >> 3));
  endfunction

  function automatic logic [AW-1:0] mk(int tag, int idx, int off);
    return {4'(tag), 3'(idx), 3'(off)};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model: logs transfers, checks written lines against reference
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req) begin
        automatic int a = int'(mem_addr);
        automatic logic w = mem_we;
        for (int k = 1; k < mem_lat; k++) @(negedge clk);
        chk(mem_req && mem_we == w && int'(mem_addr) == a, "R11", "request held", int'(mem_addr), a);
        if (w) begin
          for (int b = 0; b < 8; b++) begin
            chk(mem_wdata[b*8 +: 8] == ref_b[a+b], "R6", "written-out byte", mem_wdata[b*8 +: 8], ref_b[a+b]);
            mem_b[a+b] = mem_wdata[b*8 +: 8];
          end
        end else begin
          for (int b = 0; b < 8; b++) mem_rdata[b*8 +: 8] = mem_b[a+b];
        end
        if (ev_n < 32) begin
          ev_we[ev_n] = w;
          ev_addr[ev_n] = AW'(a);
        end
        ev_n++;
        mem_ack = 1;
        @(negedge clk);
        mem_ack = 0;
      end
    end
  end

  task automatic do_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] wd,
                       output int lat, output logic [7:0] rd);
    @(negedge clk);
    cpu_valid = 1; cpu_op = op; cpu_addr = a; cpu_wdata = wd;
    while (!cpu_ready) @(negedge clk);
    ev_n = 0;
    @(negedge clk);
    cpu_valid = 0;
    lat = 1;
    while (!cpu_rvalid) begin
      @(negedge clk);
      lat++;
    end
    rd = cpu_rdata;
    if (op == 2'b01) ref_b[a] = wd;
  endtask

  task automatic ld_hit(logic [AW-1:0] a, string req);
    int lat; logic [7:0] rd;
    do_op(2'b00, a, 8'h00, lat, rd);
    chk(lat == 1, req, "hit latency", lat, 1);
    chk(ev_n == 0, req, "hit transfers", ev_n, 0);
    chk(rd == ref_b[a], req, "hit data", rd, ref_b[a]);
  endtask

  initial begin
    int lat; logic [7:0] rd;
    for (int a = 0; a < (1<<AW); a++) begin
      mem_b[a] = init_byte(a);
      ref_b[a] = init_byte(a);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cpu_ready == 1, "R1", "ready after reset", cpu_ready, 1);
    chk(cpu_rvalid == 0, "R1", "rvalid after reset", cpu_rvalid, 0);
    chk(mem_req == 0, "R1", "mem_req after reset", mem_req, 0);

    // first access to each index misses and refills the aligned line
    for (int i = 0; i < 8; i++) begin
      mem_lat = 1 + (i % 3);
      do_op(2'b00, mk(1, i, i), 8'h00, lat, rd);
      chk(ev_n == 1 && ev_we[0] == 0, "R1", "single refill read", ev_n, 1);
      chk(ev_addr[0] == mk(1, i, 0), "R4", "refill address", ev_addr[0], mk(1, i, 0));
      chk(lat >= 2, "R4", "miss latency", lat, 2);
      chk(rd == ref_b[mk(1, i, i)], "R5", "refill byte", rd, ref_b[mk(1, i, i)]);
    end

    // every offset of every line now hits
    for (int i = 0; i < 8; i++)
      for (int o = 0; o < 8; o++) ld_hit(mk(1, i, o), "R2");

    // store hits stay in the cache
    for (int i = 0; i < 8; i++) begin
      do_op(2'b01, mk(1, i, 7 - i), 8'hA0 + 8'(i), lat, rd);
      chk(lat == 1 && ev_n == 0, "R7", "store hit no transfer", ev_n, 0);
      chk(mem_b[mk(1, i, 7 - i)] == init_byte(int'(mk(1, i, 7 - i))), "R7", "memory unchanged",
          mem_b[mk(1, i, 7 - i)], init_byte(int'(mk(1, i, 7 - i))));
      ld_hit(mk(1, i, 7 - i), "R3");
    end

    // conflict on index 0: write-out of tag 1 then refill of tag 2
    mem_lat = 2;
    do_op(2'b00, mk(2, 0, 5), 8'h00, lat, rd);
    chk(ev_n == 2, "R6", "transfer count", ev_n, 2);
    chk(ev_we[0] == 1 && ev_addr[0] == mk(1, 0, 0), "R6", "write-out first", ev_addr[0], mk(1, 0, 0));
    chk(ev_we[1] == 0 && ev_addr[1] == mk(2, 0, 0), "R6", "refill second", ev_addr[1], mk(2, 0, 0));
    chk(rd == ref_b[mk(2, 0, 5)], "R2", "new tag data", rd, ref_b[mk(2, 0, 5)]);
    chk(mem_b[mk(1, 0, 7)] == 8'hA0, "R6", "stored byte reached memory", mem_b[mk(1, 0, 7)], 8'hA0);

    // store miss on index 1
    mem_lat = 3;
    do_op(2'b01, mk(3, 1, 2), 8'h5C, lat, rd);
    chk(ev_n == 2 && ev_we[0] == 1 && ev_addr[0] == mk(1, 1, 0), "R8", "victim written out", ev_addr[0], mk(1, 1, 0));
    chk(ev_we[1] == 0 && ev_addr[1] == mk(3, 1, 0), "R8", "allocate read", ev_addr[1], mk(3, 1, 0));
    ld_hit(mk(3, 1, 2), "R8");
    ld_hit(mk(3, 1, 3), "R8");
    chk(mem_b[mk(3, 1, 2)] != 8'h5C, "R8", "store miss not written through", mem_b[mk(3, 1, 2)], 8'h5C);
    mem_lat = 1;
    do_op(2'b00, mk(1, 1, 0), 8'h00, lat, rd);
    chk(ev_n == 2 && ev_we[0] == 1 && ev_addr[0] == mk(3, 1, 0), "R8", "merged line marked modified", ev_addr[0], mk(3, 1, 0));
    chk(mem_b[mk(3, 1, 2)] == 8'h5C, "R8", "merged byte in memory", mem_b[mk(3, 1, 2)], 8'h5C);
    chk(rd == ref_b[mk(1, 1, 0)], "R5", "refill byte", rd, ref_b[mk(1, 1, 0)]);

    // clean: lines 2..7 are modified, 0 and 1 are not
    mem_lat = 2;
    do_op(2'b10, '0, 8'h00, lat, rd);
    chk(ev_n == 6, "R9", "clean transfer count", ev_n, 6);
    for (int k = 0; k < 6 && k < ev_n; k++)
      chk(ev_we[k] == 1 && ev_addr[k] == mk(1, k + 2, 0), "R9", "clean order", ev_addr[k], mk(1, k + 2, 0));
    for (int i = 2; i < 8; i++)
      chk(mem_b[mk(1, i, 7 - i)] == 8'hA0 + 8'(i), "R9", "cleaned byte", mem_b[mk(1, i, 7 - i)], 8'hA0 + 8'(i));
    do_op(2'b11, '0, 8'h00, lat, rd);
    chk(ev_n == 0, "R10", "second clean idle", ev_n, 0);
    ld_hit(mk(1, 4, 1), "R9");
    do_op(2'b00, mk(2, 4, 0), 8'h00, lat, rd);
    chk(ev_n == 1 && ev_we[0] == 0, "R10", "cleaned line not written again", ev_n, 1);
    chk(rd == ref_b[mk(2, 4, 0)], "R5", "refill byte", rd, ref_b[mk(2, 4, 0)]);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule